// File: doc/BRIEF.md
# Dual SRAM Boot Remap Decoder

This block sits between the processor's two instruction/data fetch paths and the on-chip memories. It turns a code-bus address into a target select and an offset local to that target. The target is the non-volatile memory, SRAM bank 0, SRAM bank 1, or nothing, which is a decode miss. By default the low code window shows the non-volatile memory. Software can set a remap bit so that the two equal-size SRAM banks appear at code address zero instead, as one contiguous region. A second bit picks which bank comes first.

The system bus sees the two banks at a fixed base address whatever the control bits hold. So the processor's system port and every other master keep one stable view of the SRAMs. Each request port is decoded combinationally and registered, and the result appears one cycle after the request.

The control bits are held as a four-state machine. The states are `MAP_PLAIN` (remap off), `MAP_PLAIN_SW` (remap off, swap bit stored but inactive), `MAP_LOW0` (bank 0 at zero) and `MAP_LOW1` (bank 1 at zero). Reset enters `MAP_PLAIN`. On any cycle with `cfg_we` high, the machine moves to the state named by the written bits {swap, remap}. Without a write it holds its state.

Top module: `rmp_remap_top`

## Requirements
- R1: After reset the control readback is 0, and every response output (valid, target, offset, miss) is 0.
- R2: `cfg_rdata` bit 0 returns the remap bit and bit 1 returns the swap bit as last written, and bits 31:2 read as zero. A write affects only requests presented in later cycles. A request in the same cycle as the write uses the old mapping.
- R3: With remap off, a code address below `NVM_BYTES` returns target 1 (non-volatile memory) with offset equal to the address. Neither SRAM bank is returned on the code bus.
- R4: With remap on and swap 0, code addresses [0, B) return target 2 (bank 0) with offset = address. Addresses [B, 2B) return target 3 (bank 1) with offset = address - B. B is `BANK_BYTES`.
- R5: With remap on and swap 1, code addresses [0, B) return target 3 (bank 1) and [B, 2B) return target 2 (bank 0). The offsets are computed as in R4.
- R6: While remap is off, the swap bit has no effect on any code-bus result.
- R7: A code request outside the active code window returns target 0 with miss = 1 and offset 0. The active window is [0, 2B) with remap on and [0, `NVM_BYTES`) with remap off.
- R8: System addresses [SYS_BASE, SYS_BASE+B) return bank 0 and [SYS_BASE+B, SYS_BASE+2B) return bank 1, with offset = address - window start. This holds in all four control states.
- R9: A system request outside that window returns target 0, miss = 1, offset 0. The system bus never returns the non-volatile memory.
- R10: Each port's response valid equals its request valid one cycle earlier. A cycle without a request yields target 0, offset 0 and miss 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 32 | Write data; bit 0 = remap, bit 1 = swap |
| cfg_rdata | output | 32 | Control register readback |
| code_req | input | 1 | Code-bus request valid |
| code_addr | input | 32 | Code-bus address |
| code_rsp | output | 1 | Code-bus result valid |
| code_tgt | output | 2 | Code target: 0 none, 1 NVM, 2 bank 0, 3 bank 1 |
| code_off | output | 18 | Offset within the code target |
| code_miss | output | 1 | Code request decoded to nothing |
| sys_req | input | 1 | System-bus request valid |
| sys_addr | input | 32 | System-bus address |
| sys_rsp | output | 1 | System-bus result valid |
| sys_tgt | output | 2 | System target, same encoding as code_tgt |
| sys_off | output | 18 | Offset within the system target |
| sys_miss | output | 1 | System request decoded to nothing |

## Verification
A corrupted control state shows at `cfg_rdata` in the very next cycle. It also shows one cycle after the next code request whose address falls in the low window: the wrong memory, or the right bank with the wrong order. A decode fault appears on the response ports exactly one cycle after the offending request. That request can be a boundary address, such as the last word of a bank or the first word past the pair. Because the system bus ignores the control state, any system result that differs between control states points straight at control logic leaking into the fixed view.

// File: rtl/rmp_pkg.sv
package rmp_pkg;

    // Target encoding shared by both request ports.
    typedef enum logic [1:0] {
        TGT_NONE  = 2'd0,
        TGT_NVM   = 2'd1,
        TGT_BANK0 = 2'd2,
        TGT_BANK1 = 2'd3
    } rmp_tgt_e;

    // Control state: encoding equals the register bits {swap, remap}.
    typedef enum logic [1:0] {
        MAP_PLAIN    = 2'b00,
        MAP_LOW0     = 2'b01,
        MAP_PLAIN_SW = 2'b10,
        MAP_LOW1     = 2'b11
    } rmp_map_e;

endpackage

// File: rtl/rmp_ctrl.sv
module rmp_ctrl
    import rmp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic              remap_on,
    output logic              swap_on
);

    rmp_map_e state_q, state_d;

    // Next-state: a write names the target state directly.
    always_comb begin
        state_d = state_q;
        if (cfg_we) begin
            unique case (cfg_wdata[1:0])
                2'b00:   state_d = MAP_PLAIN;
                2'b01:   state_d = MAP_LOW0;
                2'b10:   state_d = MAP_PLAIN_SW;
                default: state_d = MAP_LOW1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MAP_PLAIN;
        else        state_q <= state_d;
    end

    // Output decode of the state.
    always_comb begin
        remap_on = 1'b0;
        swap_on  = 1'b0;
        unique case (state_q)
            MAP_PLAIN:    begin remap_on = 1'b0; swap_on = 1'b0; end
            MAP_LOW0:     begin remap_on = 1'b1; swap_on = 1'b0; end
            MAP_PLAIN_SW: begin remap_on = 1'b0; swap_on = 1'b1; end
            MAP_LOW1:     begin remap_on = 1'b1; swap_on = 1'b1; end
            default:      begin remap_on = 1'b0; swap_on = 1'b0; end
        endcase
        cfg_rdata    = '0;
        cfg_rdata[0] = remap_on;
        cfg_rdata[1] = swap_on;
    end

    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg_rdata[1:0] == $past(cfg_wdata[1:0])));

    assert_hold_without_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg_rdata));

endmodule

// File: rtl/rmp_code_dec.sv
module rmp_code_dec
    import rmp_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int BANK_BYTES = 32768,
    parameter int NVM_BYTES  = 262144,
    parameter int OFF_W      = 18
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              remap_on,
    input  logic              swap_on,
    output rmp_tgt_e          tgt,
    output logic [OFF_W-1:0]  off
);

    localparam int                BANK_AW  = $clog2(BANK_BYTES);
    localparam logic [ADDR_W-1:0] PAIR_END = ADDR_W'(2 * BANK_BYTES);
    localparam logic [ADDR_W-1:0] NVM_END  = ADDR_W'(NVM_BYTES);

    logic in_pair, in_nvm, upper_half;

    always_comb begin
        in_pair    = addr < PAIR_END;
        in_nvm     = addr < NVM_END;
        upper_half = addr[BANK_AW];
        tgt        = TGT_NONE;
        off        = '0;
        if (remap_on) begin
            if (in_pair) begin
                // Swap flips which bank answers the lower half.
                tgt = (upper_half ^ swap_on) ? TGT_BANK1 : TGT_BANK0;
                off = OFF_W'(addr[BANK_AW-1:0]);
            end
        end else if (in_nvm) begin
            tgt = TGT_NVM;
            off = OFF_W'(addr[OFF_W-1:0]);
        end
    end

endmodule

// File: rtl/rmp_sys_dec.sv
module rmp_sys_dec
    import rmp_pkg::*;
#(
    parameter int              ADDR_W     = 32,
    parameter int              BANK_BYTES = 32768,
    parameter logic [31:0]     SYS_BASE   = 32'h2000_0000,
    parameter int              OFF_W      = 18
) (
    input  logic [ADDR_W-1:0] addr,
    output rmp_tgt_e          tgt,
    output logic [OFF_W-1:0]  off
);

    localparam int                BANK_AW  = $clog2(BANK_BYTES);
    localparam logic [ADDR_W-1:0] PAIR_END = ADDR_W'(2 * BANK_BYTES);
    localparam logic [ADDR_W-1:0] BASE     = ADDR_W'(SYS_BASE);

    logic [ADDR_W-1:0] rel;

    always_comb begin
        rel = addr - BASE;
        tgt = TGT_NONE;
        off = '0;
        if (addr >= BASE && rel < PAIR_END) begin
            tgt = rel[BANK_AW] ? TGT_BANK1 : TGT_BANK0;
            off = OFF_W'(rel[BANK_AW-1:0]);
        end
    end

endmodule

// File: rtl/rmp_rsp_reg.sv
module rmp_rsp_reg
    import rmp_pkg::*;
#(
    parameter int OFF_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_vld,
    input  rmp_tgt_e         dec_tgt,
    input  logic [OFF_W-1:0] dec_off,
    output logic             rsp_vld,
    output rmp_tgt_e         rsp_tgt,
    output logic [OFF_W-1:0] rsp_off,
    output logic             rsp_miss
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_vld  <= 1'b0;
            rsp_tgt  <= TGT_NONE;
            rsp_off  <= '0;
            rsp_miss <= 1'b0;
        end else begin
            rsp_vld  <= req_vld;
            rsp_tgt  <= req_vld ? dec_tgt : TGT_NONE;
            rsp_off  <= req_vld ? dec_off : '0;
            rsp_miss <= req_vld && (dec_tgt == TGT_NONE);
        end
    end

    assert_rsp_follows_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> rsp_vld);

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> (!rsp_vld && rsp_tgt == TGT_NONE && !rsp_miss && rsp_off == '0));

endmodule

// File: rtl/rmp_remap_top.sv
module rmp_remap_top
    import rmp_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          DATA_W     = 32,
    parameter int          BANK_BYTES = 32768,
    parameter int          NVM_BYTES  = 262144,
    parameter logic [31:0] SYS_BASE   = 32'h2000_0000,
    localparam int         OFF_W      = $clog2(NVM_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              code_req,
    input  logic [ADDR_W-1:0] code_addr,
    output logic              code_rsp,
    output logic [1:0]        code_tgt,
    output logic [OFF_W-1:0]  code_off,
    output logic              code_miss,
    input  logic              sys_req,
    input  logic [ADDR_W-1:0] sys_addr,
    output logic              sys_rsp,
    output logic [1:0]        sys_tgt,
    output logic [OFF_W-1:0]  sys_off,
    output logic              sys_miss
);

    localparam int N_PORT = 2;  // 0 = code bus, 1 = system bus

    logic remap_on, swap_on;

    rmp_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata),
        .remap_on (remap_on),
        .swap_on  (swap_on)
    );

    rmp_tgt_e               dec_tgt  [N_PORT];
    logic [OFF_W-1:0]       dec_off  [N_PORT];
    logic [N_PORT-1:0]      req_v;
    logic [N_PORT-1:0]      rsp_v;
    logic [N_PORT-1:0]      rsp_m;
    rmp_tgt_e               rsp_t    [N_PORT];
    logic [OFF_W-1:0]       rsp_o    [N_PORT];

    assign req_v = {sys_req, code_req};

    rmp_code_dec #(
        .ADDR_W(ADDR_W), .BANK_BYTES(BANK_BYTES), .NVM_BYTES(NVM_BYTES), .OFF_W(OFF_W)
    ) u_code_dec (
        .addr    (code_addr),
        .remap_on(remap_on),
        .swap_on (swap_on),
        .tgt     (dec_tgt[0]),
        .off     (dec_off[0])
    );

    rmp_sys_dec #(
        .ADDR_W(ADDR_W), .BANK_BYTES(BANK_BYTES), .SYS_BASE(SYS_BASE), .OFF_W(OFF_W)
    ) u_sys_dec (
        .addr(sys_addr),
        .tgt (dec_tgt[1]),
        .off (dec_off[1])
    );

    for (genvar p = 0; p < N_PORT; p++) begin : g_port
        rmp_rsp_reg #(.OFF_W(OFF_W)) u_rsp (
            .clk     (clk),
            .rst_n   (rst_n),
            .req_vld (req_v[p]),
            .dec_tgt (dec_tgt[p]),
            .dec_off (dec_off[p]),
            .rsp_vld (rsp_v[p]),
            .rsp_tgt (rsp_t[p]),
            .rsp_off (rsp_o[p]),
            .rsp_miss(rsp_m[p])
        );
    end

    assign code_rsp  = rsp_v[0];
    assign code_tgt  = rsp_t[0];
    assign code_off  = rsp_o[0];
    assign code_miss = rsp_m[0];
    assign sys_rsp   = rsp_v[1];
    assign sys_tgt   = rsp_t[1];
    assign sys_off   = rsp_o[1];
    assign sys_miss  = rsp_m[1];

    // A bank on the code bus requires remap to have been on when decoded.
    assert_bank_needs_remap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (code_tgt == TGT_BANK0 || code_tgt == TGT_BANK1) |-> $past(remap_on));

    // The NVM on the code bus requires remap off when decoded (R3, R6).
    assert_nvm_only_plain_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (code_tgt == TGT_NVM) |-> !$past(remap_on));

    assert_sys_never_nvm_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sys_tgt != TGT_NVM);

endmodule

// File: tb/test_rmp_remap_top.sv
module test_rmp_remap_top;

    localparam int          B  = 32768;
    localparam int          NV = 262144;
    localparam logic [31:0] SB = 32'h2000_0000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [31:0] cfg_wdata, cfg_rdata;
    logic        code_req, code_rsp, code_miss, sys_req, sys_rsp, sys_miss;
    logic [31:0] code_addr, sys_addr;
    logic [1:0]  code_tgt, sys_tgt;
    logic [17:0] code_off, sys_off;

    always #10 clk = ~clk;  // 50 MHz

    rmp_remap_top i_rmp_remap_top (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .code_req(code_req), .code_addr(code_addr), .code_rsp(code_rsp), .code_tgt(code_tgt),
        .code_off(code_off), .code_miss(code_miss), .sys_req(sys_req), .sys_addr(sys_addr),
        .sys_rsp(sys_rsp), .sys_tgt(sys_tgt), .sys_off(sys_off), .sys_miss(sys_miss)
    );

    typedef struct packed {
        logic cv; logic [1:0] ct; logic [17:0] co; logic cm;
        logic sv; logic [1:0] st; logic [17:0] so; logic sm;
    } exp_t;

    exp_t  q_exp[$];
    string q_tag[$];
    int    n_chk = 0;
    int    n_bad = 0;
    bit    b_rm = 1'b0;
    bit    b_sw = 1'b0;
    bit    done = 1'b0;

    function automatic exp_t model(logic cv, logic [31:0] ca, logic sv, logic [31:0] sa, bit rm, bit sw);
        exp_t e = '0;
        e.cv = cv;
        e.sv = sv;
        if (cv) begin
            if (rm && ca < 32'(2 * B)) begin
                e.ct = ((ca >= 32'(B)) ^ sw) ? 2'd3 : 2'd2;
                e.co = 18'(ca % 32'(B));
            end else if (!rm && ca < 32'(NV)) begin
                e.ct = 2'd1;
                e.co = 18'(ca);
            end else e.cm = 1'b1;
        end
        if (sv) begin
            if (sa >= SB && (sa - SB) < 32'(2 * B)) begin
                e.st = ((sa - SB) >= 32'(B)) ? 2'd3 : 2'd2;
                e.so = 18'((sa - SB) % 32'(B));
            end else e.sm = 1'b1;
        end
        return e;
    endfunction

    // Driver: one call per cycle, pushes one expected item per cycle.
    task automatic step(logic cv, logic [31:0] ca, logic sv, logic [31:0] sa,
                        logic we, logic [31:0] wd, string tag);
        @(negedge clk);
        code_req = cv; code_addr = ca; sys_req = sv; sys_addr = sa;
        cfg_we = we; cfg_wdata = wd;
        q_exp.push_back(model(cv, ca, sv, sa, b_rm, b_sw));
        q_tag.push_back(tag);
        if (we) begin b_rm = wd[0]; b_sw = wd[1]; end
    endtask

    task automatic rd_chk(logic [31:0] exp, string tag);
        n_chk++;
        if (cfg_rdata !== exp) begin
            n_bad++;
            $display("FAIL %s readback act=%h exp=%h", tag, cfg_rdata, exp);
        end
    endtask

    // Monitor: compares a quarter period after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (q_exp.size() > 0) begin
                exp_t  e;
                exp_t  a;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                a = {code_rsp, code_tgt, code_off, code_miss, sys_rsp, sys_tgt, sys_off, sys_miss};
                n_chk++;
                if (a !== e) begin
                    n_bad++;
                    $display("FAIL %s response act=%h exp=%h", t, a, e);
                end
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] ca[9];
        logic [31:0] sa[6];
        string       mt;
        ca = '{32'd0, 32'd4, 32'(B - 4), 32'(B), 32'(B + 4), 32'(2 * B - 4), 32'(2 * B),
               32'(NV - 4), 32'(NV)};
        sa = '{SB, SB + 32'(B - 4), SB + 32'(B), SB + 32'(2 * B - 4), SB + 32'(2 * B), SB - 32'd4};
        rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0;
        code_req = 1'b0; code_addr = '0; sys_req = 1'b0; sys_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        rd_chk(32'd0, "R1");
        n_chk++;
        if ({code_rsp, code_tgt, code_off, code_miss, sys_rsp, sys_tgt, sys_off, sys_miss} !== '0) begin
            n_bad++;
            $display("FAIL R1 outputs act=%b%h%h%b exp=0", code_rsp, code_tgt, code_off, sys_rsp);
        end

        for (int m = 0; m < 4; m++) begin
            step(1'b0, '0, 1'b0, '0, 1'b1, 32'(m), "R2");
            step(1'b0, '0, 1'b0, '0, 1'b0, '0, "R10");
            rd_chk(32'(m), "R2");
            case (m)
                0: mt = "R3";
                1: mt = "R4";
                2: mt = "R6";
                default: mt = "R5";
            endcase
            for (int i = 0; i < 9; i++) begin
                exp_t pe;
                pe = model(1'b1, ca[i], 1'b0, '0, m[0], m[1]);
                step(1'b1, ca[i], 1'b0, '0, 1'b0, '0, pe.cm ? "R7" : mt);
            end
            for (int i = 0; i < 6; i++)
                step(1'b0, '0, 1'b1, sa[i], 1'b0, '0, (i >= 4) ? "R9" : "R8");
        end

        // R2: upper bits written as ones still read zero
        step(1'b0, '0, 1'b0, '0, 1'b1, 32'hFFFF_FFFD, "R2");
        step(1'b0, '0, 1'b0, '0, 1'b0, '0, "R10");
        rd_chk(32'd1, "R2");
        // R2: request in the write cycle uses the old mapping, next one the new
        step(1'b1, 32'(B), 1'b1, SB, 1'b1, 32'd3, "R2");
        step(1'b1, 32'(B), 1'b1, SB, 1'b0, '0, "R5");
        step(1'b1, 32'd8, 1'b0, '0, 1'b0, '0, "R10");
        step(1'b0, '0, 1'b1, SB + 32'd8, 1'b0, '0, "R10");
        step(1'b0, '0, 1'b0, '0, 1'b0, '0, "R10");
        step(1'b0, '0, 1'b0, '0, 1'b0, '0, "R10");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule